// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block is one timer channel that drives a single pulse-width-modulated output. A 16-bit up-counter steps on a divided clock tick, restarts from zero after it reaches the full (period) compare value, and produces a one-cycle pulse when it does. A second, half (duty) compare value marks the point within each period where the output leaves its resting level and turns active. Software programs the channel through a simple write port. The registers are a control word, the full and half compare values, and the counter itself. A separate `run` input starts and stops counting.

The control word has four fields. Bits [2:0] pick the clock divider, bit 3 gates the output on, bit 4 inverts the output, and bit 5 selects abrupt instead of graceful shutdown. The output is produced by a four-state machine. The states are IDLE (output gated off, resting level), ARMED (gated on, resting level, waiting for the half match), DRIVE (active level) and DRAIN (gate cleared, still active until the period ends). The transitions are ENABLE (IDLE to ARMED, or to DRIVE on a simultaneous half match), HALF_MATCH (ARMED to DRIVE), PERIOD_END (DRIVE to ARMED), RELOAD (a counter write in DRIVE returns to ARMED), GATE_OFF (ARMED to IDLE, or DRIVE to IDLE under abrupt shutdown), SOFT_STOP (DRIVE to DRAIN), REARM (DRAIN to DRIVE when the gate is set again) and FLUSH (DRAIN to IDLE on a period end, a counter write or abrupt mode).

Top module: `pwmtmr_channel`

## Requirements
- R1: After reset the counter reads 0, `pwm_out` is 0 and `period_hit` is 0. All registers are cleared, so the output is gated off.
- R2: Divider field value s (bits [2:0] of the control word) makes the counter step once every 4^s clock cycles while `run` is high. Values 6 and 7 behave as 5, which is a divide by 1024.
- R3: The counter steps 0, 1, … up to the full value, then returns to 0 on the next tick. A full value of 0xFFFF is valid and wraps from 0xFFFF to 0.
- R4: With the output gated on and the waveform started by a counter write, the output is at its resting level while count < half value. It is active while half value ≤ count ≤ full value. The resting level is 0 and the active level is 1. Setting control bit 4 swaps the two levels.
- R5: When the half value is greater than the full value, the output stays at its resting level through every period.
- R6: `period_hit` is high for exactly one cycle. That cycle is the first one in which the counter shows 0 after stepping from the full value.
- R7: While `run` is low, the counter and the divider hold their values.
- R8: With control bit 5 set, clearing control bit 3 while the output is active returns the output to its resting level on the clock edge after the control register takes the write. The current period does not run out first.
- R9: With control bit 5 clear, clearing control bit 3 while active leaves the output active until the counter wraps to 0. From then on the output stays at its resting level, including through later half matches.
- R10: A write to the counter (select 3) loads `wr_data[15:0]` and is visible on `count` in the next cycle. It takes priority over a tick in the same cycle.
- R11: A write to the control register (select 0) clears the divider, so the next counter step comes a full 4^s cycles after that write.
- R12: Clearing control bit 3 does not stop the counter. The counter keeps stepping and wrapping while the output is gated off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Counter enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 full value, 2 half value, 3 counter |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM output |
| period_hit | output | 1 | One-cycle pulse when the counter wraps after the full value |
| count | output | 16 | Current counter value |

## Verification
The hardest situation to reach is graceful shutdown in flight. The gate has to be cleared in the narrow window after the half match and before the period ends. The bench must then show that the output holds active across the remaining counts and drops exactly at the wrap. It must also show that the output never comes back at later half matches while the counter keeps running. Directed stimulus polls the counter until it sits between the two compare values, then issues the control write, so that the DRAIN state is entered deterministically. A similar timed write, five cycles after a counter step with a divide by 16, separates a cleared divider from a free-running one. Random configurations of divider, polarity and compare values, including half values above the full value, cover the steady waveform.

// File: rtl/pwmtmr_pkg.sv
package pwmtmr_pkg;

    // register select codes on the write port
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_FULL  = 2'd1,
        SEL_HALF  = 2'd2,
        SEL_COUNT = 2'd3
    } reg_sel_e;

    // control word field positions
    localparam int CTRL_DIV_LSB = 0;
    localparam int CTRL_DIV_W   = 3;
    localparam int CTRL_GATE    = 3;
    localparam int CTRL_INVERT  = 4;
    localparam int CTRL_ABRUPT  = 5;

    typedef struct packed {
        logic                  abrupt;
        logic                  invert;
        logic                  gate;
        logic [CTRL_DIV_W-1:0] div_sel;
    } ctrl_t;

    // output waveform states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DRIVE = 2'd2,
        ST_DRAIN = 2'd3
    } wave_st_e;

endpackage

// File: rtl/pwmtmr_prescale.sv
module pwmtmr_prescale #(
    parameter int PS_STEPS = 6,
    parameter int PS_SHIFT = 2,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = PS_SHIFT * (PS_STEPS - 1);

    logic [DIV_W-1:0] lim_tab [PS_STEPS];
    logic [DIV_W-1:0] limit;
    logic [DIV_W-1:0] div_q;
    logic [SEL_W-1:0] sel_eff;

    genvar g;
    generate
        for (g = 0; g < PS_STEPS; g++) begin : g_lim
            localparam int unsigned LIMG = (1 << (PS_SHIFT * g)) - 1;
            assign lim_tab[g] = DIV_W'(LIMG);
        end
    endgenerate

    // out-of-range selections saturate to the slowest step
    assign sel_eff = (sel > SEL_W'(PS_STEPS - 1)) ? SEL_W'(PS_STEPS - 1) : sel;

    always_comb begin
        limit = '0;
        for (int i = 0; i < PS_STEPS; i++) begin
            if (sel_eff == SEL_W'(i)) limit = lim_tab[i];
        end
    end

    assign tick = run && (div_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       div_q <= '0;
        else if (clr)     div_q <= '0;
        else if (run)     div_q <= tick ? '0 : div_q + DIV_W'(1);
    end

    // R7: divider frozen while stopped
    a_r7_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(div_q));

    // R2: a divided setting never ticks on two cycles in a row
    a_r2_spaced_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_eff != '0 && tick && !clr) |=> (!tick || sel_eff == '0));

endmodule

// File: rtl/pwmtmr_counter.sv
module pwmtmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] full,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] nxt,
    output logic             upd,
    output logic             wrap,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;
    logic             hit_q;

    // a load overrides the period end in the same cycle
    assign wrap = tick && !ld && (cnt_q == full);
    assign upd  = tick || ld;

    always_comb begin
        if (ld)        nxt = ld_val;
        else if (wrap) nxt = '0;
        else           nxt = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            hit_q <= 1'b0;
        end else begin
            if (upd) cnt_q <= nxt;
            hit_q <= wrap;
        end
    end

    assign cnt = cnt_q;
    assign hit = hit_q;

    // R6: the match pulse coincides with a zero count
    a_r6_hit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> (cnt_q == '0));

    // R7: counter holds when neither ticked nor loaded
    a_r7_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld) |=> $stable(cnt_q));

    // R3: reaching the full value on a tick restarts from zero
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && cnt_q == full) |=> (cnt_q == '0 && hit_q));

endmodule

// File: rtl/pwmtmr_wave.sv
module pwmtmr_wave
    import pwmtmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate,
    input  logic             invert,
    input  logic             abrupt,
    input  logic             upd,
    input  logic             ld,
    input  logic             wrap,
    input  logic [CNT_W-1:0] nxt,
    input  logic [CNT_W-1:0] half,
    input  logic [CNT_W-1:0] full,
    output logic             pwm_out
);
    wave_st_e st_q, st_d;
    logic     half_match;

    // a half match only counts when it lies inside the period
    assign half_match = upd && (nxt == half) && (half <= full);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (gate) st_d = half_match ? ST_DRIVE : ST_ARMED;
            end
            ST_ARMED: begin
                if (!gate)           st_d = ST_IDLE;
                else if (half_match) st_d = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (!gate)              st_d = (abrupt || wrap) ? ST_IDLE : ST_DRAIN;
                else if (half_match)    st_d = ST_DRIVE;
                else if (wrap || ld)    st_d = ST_ARMED;
            end
            ST_DRAIN: begin
                if (abrupt || wrap || ld) st_d = ST_IDLE;
                else if (gate)            st_d = ST_DRIVE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        pwm_out = ((st_q == ST_DRIVE) || (st_q == ST_DRAIN)) ^ invert;
    end

    // R5: a half value beyond the period never activates the output
    a_r5_no_drive_over: assert property (@(posedge clk) disable iff (!rst_n)
        (half > full && st_q == ST_ARMED) |=> (st_q != ST_DRIVE));

    // R8: abrupt mode with the gate cleared always lands in IDLE
    a_r8_abrupt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (abrupt && !gate) |=> (st_q == ST_IDLE));

    // R9: graceful drain persists until the period ends
    a_r9_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DRAIN && !abrupt && !gate && !wrap && !ld) |=> (st_q == ST_DRAIN));

endmodule

// File: rtl/pwmtmr_channel.sv
module pwmtmr_channel
    import pwmtmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PS_STEPS = 6,
    parameter int PS_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic             period_hit,
    output logic [CNT_W-1:0] count
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] full_q, half_q;
    logic             wr_ctrl, wr_full, wr_half, wr_cnt;
    logic             tick, upd, wrap;
    logic [CNT_W-1:0] nxt;

    assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
    assign wr_full = wr_en && (wr_sel == SEL_FULL);
    assign wr_half = wr_en && (wr_sel == SEL_HALF);
    assign wr_cnt  = wr_en && (wr_sel == SEL_COUNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            full_q <= '0;
            half_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.div_sel <= wr_data[CTRL_DIV_LSB +: CTRL_DIV_W];
                ctrl_q.gate    <= wr_data[CTRL_GATE];
                ctrl_q.invert  <= wr_data[CTRL_INVERT];
                ctrl_q.abrupt  <= wr_data[CTRL_ABRUPT];
            end
            if (wr_full) full_q <= wr_data;
            if (wr_half) half_q <= wr_data;
        end
    end

    pwmtmr_prescale #(
        .PS_STEPS(PS_STEPS),
        .PS_SHIFT(PS_SHIFT),
        .SEL_W   (CTRL_DIV_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .clr  (wr_ctrl),
        .sel  (ctrl_q.div_sel),
        .tick (tick)
    );

    pwmtmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .ld    (wr_cnt),
        .ld_val(wr_data),
        .full  (full_q),
        .cnt   (count),
        .nxt   (nxt),
        .upd   (upd),
        .wrap  (wrap),
        .hit   (period_hit)
    );

    pwmtmr_wave #(.CNT_W(CNT_W)) u_wave (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate   (ctrl_q.gate),
        .invert (ctrl_q.invert),
        .abrupt (ctrl_q.abrupt),
        .upd    (upd),
        .ld     (wr_cnt),
        .wrap   (wrap),
        .nxt    (nxt),
        .half   (half_q),
        .full   (full_q),
        .pwm_out(pwm_out)
    );

    // R10: a counter write is visible on the next cycle
    a_r10_load_seen: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (count == $past(wr_data)));

    // R12: clearing the gate leaves counting untouched
    a_r12_count_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.gate && tick && !wr_cnt && count != full_q) |=> (count == $past(count) + CNT_W'(1)));

endmodule

// File: tb/sim_pwmtmr_channel.sv
`timescale 1ns/1ps
module sim_pwmtmr_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        pwm_out, period_hit;
    logic [15:0] count;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    pwmtmr_channel u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pwm_out(pwm_out), .period_hit(period_hit), .count(count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int f_div(input int s);
        return (s > 5) ? 1024 : (1 << (2 * s));
    endfunction

    function automatic bit f_level(input int c, input int h, input int f, input bit inv);
        return ((h <= f) && (c >= h)) ^ inv;
    endfunction

    function automatic logic [15:0] f_ctrl(input int s, input bit gate, input bit inv, input bit abr);
        return {10'd0, abr, inv, gate, 3'(s)};
    endfunction

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input int s, input int f, input int h, input bit inv, input bit abr);
        run = 1'b0;
        wr(2'd0, f_ctrl(s, 1'b1, inv, abr));
        wr(2'd1, 16'(f));
        wr(2'd2, 16'(h));
        wr(2'd3, 16'd0);
    endtask

    // steady-state run with per-cycle checks (R2 R3 R4 R5 R6)
    task automatic run_check(input int s, input int f, input int h, input bit inv, input int cycles);
        int k = 0;
        int prev;
        @(negedge clk);
        prev = count;
        run = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            int c;
            bit chg;
            @(negedge clk);
            k++;
            c = count;
            chg = (c != prev);
            if (chg) begin
                chk(k == f_div(s), "R2 step interval", k, f_div(s));
                chk(c == ((prev == f) ? 0 : prev + 1), "R3 count sequence", c, (prev == f) ? 0 : prev + 1);
                k = 0;
            end
            chk(period_hit == (chg && c == 0), "R6 period_hit", period_hit, chg && c == 0);
            if (h > f) chk(pwm_out == inv, "R5 held at resting level", pwm_out, inv);
            else       chk(pwm_out == f_level(c, h, f, inv), "R4 waveform level", pwm_out, f_level(c, h, f, inv));
            prev = c;
        end
        run = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(count == 0, "R1 count after reset", count, 0);
        chk(pwm_out == 0, "R1 pwm after reset", pwm_out, 0);
        chk(period_hit == 0, "R1 hit after reset", period_hit, 0);

        // R10 load while stopped, R7 hold while stopped
        wr(2'd3, 16'h1234);
        chk(count == 16'h1234, "R10 counter load", count, 16'h1234);
        repeat (10) @(negedge clk);
        chk(count == 16'h1234, "R7 hold while stopped", count, 16'h1234);

        // R10 load wins over a same-cycle tick
        wr(2'd1, 16'd100);
        wr(2'd0, f_ctrl(0, 1'b0, 1'b0, 1'b0));
        @(negedge clk);
        run = 1'b1;
        wr(2'd3, 16'd5);
        chk(count == 16'd5, "R10 load priority over tick", count, 5);
        @(negedge clk);
        chk(count == 16'd6, "R10 counting resumes after load", count, 6);
        run = 1'b0;

        // R3 full value of 0xFFFF
        wr(2'd1, 16'hFFFF);
        wr(2'd3, 16'hFFFE);
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        chk(count == 16'hFFFF, "R3 reaches 0xFFFF", count, 16'hFFFF);
        @(negedge clk);
        chk(count == 16'h0000, "R3 wraps from 0xFFFF", count, 0);
        chk(period_hit == 1'b1, "R6 hit at 0xFFFF wrap", period_hit, 1);
        @(negedge clk);
        chk(period_hit == 1'b0, "R6 hit lasts one cycle", period_hit, 0);
        run = 1'b0;

        // R5 directed: half above full, inverted polarity
        setup(0, 5, 6, 1'b1, 1'b0);
        run_check(0, 5, 6, 1'b1, 20);

        // R2 slowest step and saturated selection
        setup(5, 1, 1, 1'b0, 1'b0);
        run_check(5, 1, 1, 1'b0, 2 * 2 * 1024 + 3);
        setup(7, 1, 0, 1'b0, 1'b0);
        run_check(7, 1, 0, 1'b0, 2 * 2 * 1024 + 3);

        // random configurations (R2 R3 R4 R5 R6)
        for (int t = 0; t < 16; t++) begin
            int s = $urandom_range(0, 2);
            int f = $urandom_range(1, 12);
            int h = $urandom_range(0, f + 2);
            bit inv = 1'($urandom_range(0, 1));
            bit abr = 1'($urandom_range(0, 1));
            setup(s, f, h, inv, abr);
            run_check(s, f, h, inv, (f + 1) * f_div(s) * 2 + 3);
        end

        // R8 abrupt shutdown
        setup(0, 10, 3, 1'b0, 1'b1);
        @(negedge clk);
        run = 1'b1;
        while (count != 16'd6) @(negedge clk);
        chk(pwm_out == 1'b1, "R8 active before shutdown", pwm_out, 1);
        wr(2'd0, f_ctrl(0, 1'b0, 1'b0, 1'b1));
        @(negedge clk);
        chk(pwm_out == 1'b0, "R8 abrupt drop", pwm_out, 0);
        chk(count != 16'd0, "R8 drop before period end", count, 9);
        run = 1'b0;

        // R9 graceful shutdown, R12 counter keeps running
        setup(0, 10, 3, 1'b0, 1'b0);
        @(negedge clk);
        run = 1'b1;
        while (count != 16'd6) @(negedge clk);
        wr(2'd0, f_ctrl(0, 1'b0, 1'b0, 1'b0));
        while (count != 16'd0) begin
            chk(pwm_out == 1'b1, "R9 held active until wrap", pwm_out, 1);
            @(negedge clk);
        end
        chk(pwm_out == 1'b0, "R9 resting at wrap", pwm_out, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(pwm_out == 1'b0, "R9 stays resting past half", pwm_out, 0);
        end
        chk(count == 16'd5, "R12 counter runs while gated off", count, 5);
        run = 1'b0;

        // R11 control write clears the divider
        setup(2, 30, 40, 1'b0, 1'b0);
        @(negedge clk);
        run = 1'b1;
        begin
            int snap = count;
            int k = 0;
            while (count == snap) @(negedge clk);
            repeat (5) @(negedge clk);
            wr_en = 1'b1; wr_sel = 2'd0; wr_data = f_ctrl(2, 1'b1, 1'b0, 1'b0);
            snap = count;
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0;
            while (count == snap && k < 40) begin
                @(negedge clk);
                k++;
            end
            chk(k == 16, "R11 divider cleared by control write", k, 16);
        end
        run = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule